// File: doc/BRIEF.md
# Merging Miss Tracker for a Memory-Side Cache

This block records cache-line misses that are still waiting for memory. Misses are grouped by line. Each new miss is filed under its line tag. The block reports at once whether a miss to the same line is already waiting, so the upstream stage sends only the first miss of a line on to memory. The other misses wait in the group and are not sent.

When memory returns a line, a fill notification is presented. If a waiting group matches the fill, that group becomes the active replay chain. The chain hands back its waiting requests through a top/pop port, oldest first, one request per pop. After the last pop the group is released. A fill that carries writeback data is ignored, and so is a fill whose line has no waiting group. The block also keeps occupancy and event counters. The requests themselves are stored only as an ID and a read/write flag. Line data and the cache array lookup live outside the block.

Top module: `merge_mshr`

## Requirements
- R1: The line tag is the address with its low log2(LINE_BYTES) bits forced to zero. Two addresses in the same line share one group, and chain_tag_o shows that aligned tag.
- R2: merge_o is 1 exactly when a group with the tag of alloc_addr_i holds at least one request. It is 0 otherwise.
- R3: The active chain presents its requests in arrival order. The chain-top outputs stay stable until a pop.
- R4: fill_ready_o is 0 while a chain is active. A fill presented then has no effect on the chain or on fill_cnt_o.
- R5: A fill with fill_wb_i=1, or a fill that matches no waiting group, starts no chain. chain_valid_o stays 0.
- R6: Each pop removes one request. When the last request of the active group is popped, chain_valid_o falls and the group is released, so the next miss to that line reports merge_o=0.
- R7: full_o is 1 in two cases: the tag matches a group whose N_SLOTS slots are all occupied, or the tag matches no group and no group is free. An allocation while full_o=1 is dropped. It is not stored, not counted and never replayed.
- R8: used_o counts the requests being held. peak_o is the largest value used_o has reached since reset.
- R9: miss_cnt_o counts accepted misses, merge_cnt_o counts accepted misses that merged, and fill_cnt_o counts fills that started a chain.
- R10: After reset, chain_valid_o=0, fill_ready_o=1, full_o=0 and all counters read 0.
- R11: A miss that merges into the active group during replay is appended to the end of the chain. This holds even when it arrives in the same cycle as the pop of the last remaining entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | A new miss is presented |
| alloc_addr_i | input | ADDR_W | Byte address of the miss |
| alloc_id_i | input | ID_W | Request ID to store |
| alloc_write_i | input | 1 | Set when the miss is a write |
| merge_o | output | 1 | A group with the same line tag already exists |
| full_o | output | 1 | The presented miss cannot be accepted |
| fill_valid_i | input | 1 | A line returned from memory |
| fill_addr_i | input | ADDR_W | Address of the returned line |
| fill_wb_i | input | 1 | The returned item is writeback data |
| fill_ready_o | output | 1 | A fill may be accepted this cycle |
| chain_valid_o | output | 1 | A replay chain is active |
| chain_id_o | output | ID_W | ID of the oldest waiting request in the chain |
| chain_write_o | output | 1 | Write flag of that request |
| chain_tag_o | output | ADDR_W | Aligned tag of the active chain |
| chain_pop_i | input | 1 | Remove the chain-top request |
| used_o | output | USED_W | Requests currently held |
| peak_o | output | USED_W | High-water mark of used_o |
| miss_cnt_o | output | CNT_W | Accepted misses |
| merge_cnt_o | output | CNT_W | Accepted misses that merged |
| fill_cnt_o | output | CNT_W | Fills that started a chain |

## Verification
The assertions check the cycle-level relations on every cycle:
- The chain top holds steady until a pop.
- A pop lowers the occupancy by one, unless a push lands in the same cycle.
- Dropped allocations and fills that arrive during replay leave the counters unchanged, and writeback fills never start a chain.
- The merge count never exceeds the miss count, and the peak never falls.

Only the bench scenarios can show the end-to-end facts:
- The oldest-first order across a whole chain, and line alignment of tags.
- A released group truly restarting as a new first miss.
- A dropped request never appearing in any later replay.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int ID_W = 8;

  typedef struct packed {
    logic            write;
    logic [ID_W-1:0] id;
  } req_t;
endpackage

// File: rtl/mshr_group.sv
// One line group: aligned tag plus a circular queue of waiting requests.
module mshr_group #(
  parameter int ADDR_W  = 32,
  parameter int N_SLOTS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic [ADDR_W-1:0]   tag_i,
  input  mshr_pkg::req_t      req_i,
  input  logic                pop_i,
  output logic                valid_o,
  output logic                full_o,
  output logic                last_o,
  output logic [ADDR_W-1:0]   tag_o,
  output mshr_pkg::req_t      head_o
);
  localparam int PTR_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam int CNT_W = $clog2(N_SLOTS + 1);

  mshr_pkg::req_t     slots_q [N_SLOTS];
  logic [PTR_W-1:0]   wr_q, rd_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  tag_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(N_SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      tag_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
      if (push_i && cnt_q == '0) tag_q <= tag_i;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) slots_q[wr_q] <= req_i;
  end

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CNT_W'(N_SLOTS));
  assign last_o  = (cnt_q == CNT_W'(1));
  assign tag_o   = tag_q;
  assign head_o  = slots_q[rd_q];
endmodule

// File: rtl/mshr_match.sv
// Tag comparator across all live groups.
module mshr_match #(
  parameter int N_GROUPS = 4,
  parameter int ADDR_W   = 32,
  localparam int IDX_W   = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
  input  logic [N_GROUPS-1:0] valid_i,
  input  logic [ADDR_W-1:0]   tags_i [N_GROUPS],
  input  logic [ADDR_W-1:0]   query_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (valid_i[g] && tags_i[g] == query_i) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(g);
      end
    end
  end
endmodule

// File: rtl/mshr_stats.sv
// Occupancy, high-water mark and event counters.
module mshr_stats #(
  parameter int USED_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              merge_i,
  input  logic              start_i,
  input  logic              pop_i,
  output logic [USED_W-1:0] used_o,
  output logic [USED_W-1:0] peak_o,
  output logic [CNT_W-1:0]  miss_o,
  output logic [CNT_W-1:0]  merge_o,
  output logic [CNT_W-1:0]  fill_o
);
  logic [USED_W-1:0] used_d;

  always_comb begin
    used_d = used_o;
    if (push_i && !pop_i) used_d = used_o + 1'b1;
    if (!push_i && pop_i) used_d = used_o - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_o  <= '0;
      peak_o  <= '0;
      miss_o  <= '0;
      merge_o <= '0;
      fill_o  <= '0;
    end else begin
      used_o <= used_d;
      if (used_d > peak_o) peak_o <= used_d;
      if (push_i) miss_o <= miss_o + 1'b1;
      if (push_i && merge_i) merge_o <= merge_o + 1'b1;
      if (start_i) fill_o <= fill_o + 1'b1;
    end
  end
endmodule

// File: rtl/merge_mshr.sv
module merge_mshr #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int N_GROUPS   = 4,
  parameter int N_SLOTS    = 4,
  parameter int CNT_W      = 16,
  localparam int ID_W      = mshr_pkg::ID_W,
  localparam int USED_W    = $clog2(N_GROUPS * N_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [ID_W-1:0]   alloc_id_i,
  input  logic              alloc_write_i,
  output logic              merge_o,
  output logic              full_o,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              fill_wb_i,
  output logic              fill_ready_o,
  output logic              chain_valid_o,
  output logic [ID_W-1:0]   chain_id_o,
  output logic              chain_write_o,
  output logic [ADDR_W-1:0] chain_tag_o,
  input  logic              chain_pop_i,
  output logic [USED_W-1:0] used_o,
  output logic [USED_W-1:0] peak_o,
  output logic [CNT_W-1:0]  miss_cnt_o,
  output logic [CNT_W-1:0]  merge_cnt_o,
  output logic [CNT_W-1:0]  fill_cnt_o
);
  localparam int OFFS_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 0;
  localparam int IDX_W  = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
  localparam logic [ADDR_W-1:0] OFFS_MASK = ADDR_W'((64'd1 << OFFS_W) - 64'd1);

  logic [ADDR_W-1:0]   alloc_tag, fill_tag;
  logic [N_GROUPS-1:0] grp_valid, grp_full, grp_last, grp_push, grp_pop;
  logic [ADDR_W-1:0]   grp_tag [N_GROUPS];
  mshr_pkg::req_t      grp_head [N_GROUPS];
  mshr_pkg::req_t      new_req;

  logic             a_hit, f_hit, free_any;
  logic [IDX_W-1:0] a_idx, f_idx, free_idx, tgt_idx;
  logic             alloc_fire, fill_start, pop_fire, act_clear;
  logic             act_q;
  logic [IDX_W-1:0] act_idx_q;

  assign alloc_tag = alloc_addr_i & ~OFFS_MASK;
  assign fill_tag  = fill_addr_i & ~OFFS_MASK;
  assign new_req   = '{write: alloc_write_i, id: alloc_id_i};

  mshr_match #(.N_GROUPS(N_GROUPS), .ADDR_W(ADDR_W)) u_alloc_match (
    .valid_i(grp_valid), .tags_i(grp_tag), .query_i(alloc_tag),
    .hit_o(a_hit), .idx_o(a_idx)
  );

  mshr_match #(.N_GROUPS(N_GROUPS), .ADDR_W(ADDR_W)) u_fill_match (
    .valid_i(grp_valid), .tags_i(grp_tag), .query_i(fill_tag),
    .hit_o(f_hit), .idx_o(f_idx)
  );

  // lowest-index empty group
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int g = N_GROUPS - 1; g >= 0; g--) begin
      if (!grp_valid[g]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(g);
      end
    end
  end

  assign merge_o    = a_hit;
  assign full_o     = a_hit ? grp_full[a_idx] : !free_any;
  assign alloc_fire = alloc_valid_i && !full_o;
  assign tgt_idx    = a_hit ? a_idx : free_idx;

  assign fill_ready_o = !act_q;
  assign fill_start   = fill_valid_i && !act_q && f_hit && !fill_wb_i;
  assign pop_fire     = chain_pop_i && act_q;

  always_comb begin
    grp_push = '0;
    grp_pop  = '0;
    if (alloc_fire) grp_push[tgt_idx]  = 1'b1;
    if (pop_fire)   grp_pop[act_idx_q] = 1'b1;
  end

  // chain ends only if the last entry leaves with no concurrent append
  assign act_clear = pop_fire && grp_last[act_idx_q] && !grp_push[act_idx_q];

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    mshr_group #(.ADDR_W(ADDR_W), .N_SLOTS(N_SLOTS)) u_group (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (grp_push[g]),
      .tag_i   (alloc_tag),
      .req_i   (new_req),
      .pop_i   (grp_pop[g]),
      .valid_o (grp_valid[g]),
      .full_o  (grp_full[g]),
      .last_o  (grp_last[g]),
      .tag_o   (grp_tag[g]),
      .head_o  (grp_head[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      act_idx_q <= '0;
    end else if (fill_start) begin
      act_q     <= 1'b1;
      act_idx_q <= f_idx;
    end else if (act_clear) begin
      act_q     <= 1'b0;
    end
  end

  assign chain_valid_o = act_q;
  assign chain_id_o    = grp_head[act_idx_q].id;
  assign chain_write_o = grp_head[act_idx_q].write;
  assign chain_tag_o   = grp_tag[act_idx_q];

  mshr_stats #(.USED_W(USED_W), .CNT_W(CNT_W)) u_stats (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (alloc_fire),
    .merge_i (a_hit),
    .start_i (fill_start),
    .pop_i   (pop_fire),
    .used_o  (used_o),
    .peak_o  (peak_o),
    .miss_o  (miss_cnt_o),
    .merge_o (merge_cnt_o),
    .fill_o  (fill_cnt_o)
  );
endmodule

// File: rtl/merge_mshr_checker.sv
module merge_mshr_checker #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8,
  parameter int USED_W = 5,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alloc_valid_i,
  input logic              full_o,
  input logic              merge_o,
  input logic              fill_valid_i,
  input logic              fill_wb_i,
  input logic              chain_valid_o,
  input logic              chain_pop_i,
  input logic [ID_W-1:0]   chain_id_o,
  input logic [ADDR_W-1:0] chain_tag_o,
  input logic [USED_W-1:0] used_o,
  input logic [USED_W-1:0] peak_o,
  input logic [CNT_W-1:0]  miss_cnt_o,
  input logic [CNT_W-1:0]  merge_cnt_o,
  input logic [CNT_W-1:0]  fill_cnt_o
);
  a_r3_top_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_valid_o && !chain_pop_i |=> chain_valid_o && $stable(chain_id_o) && $stable(chain_tag_o));

  a_r4_no_fill_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_valid_o |=> fill_cnt_o == $past(fill_cnt_o));

  a_r5_wb_no_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_valid_o && fill_valid_i && fill_wb_i |=> !chain_valid_o);

  a_r6_pop_frees_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_valid_o && chain_pop_i && !(alloc_valid_i && !full_o)
      |=> used_o == $past(used_o) - USED_W'(1));

  a_r7_full_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i && full_o |=> miss_cnt_o == $past(miss_cnt_o));

  a_r8_peak_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_o <= peak_o);

  a_r8_peak_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> peak_o >= $past(peak_o));

  a_r9_merge_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i && !full_o && merge_o |=> merge_cnt_o == $past(merge_cnt_o) + CNT_W'(1));

  a_r9_merge_le_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_cnt_o <= miss_cnt_o);
endmodule

bind merge_mshr merge_mshr_checker #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .USED_W(USED_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .alloc_valid_i(alloc_valid_i), .full_o(full_o),
  .merge_o(merge_o), .fill_valid_i(fill_valid_i), .fill_wb_i(fill_wb_i),
  .chain_valid_o(chain_valid_o), .chain_pop_i(chain_pop_i), .chain_id_o(chain_id_o),
  .chain_tag_o(chain_tag_o), .used_o(used_o), .peak_o(peak_o),
  .miss_cnt_o(miss_cnt_o), .merge_cnt_o(merge_cnt_o), .fill_cnt_o(fill_cnt_o)
);

// File: tb/merge_mshr_test.sv
module merge_mshr_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int ID_W   = mshr_pkg::ID_W;
  localparam int USED_W = 5;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic alloc_valid_i = 1'b0, alloc_write_i = 1'b0;
  logic [ADDR_W-1:0] alloc_addr_i = '0, fill_addr_i = '0;
  logic [ID_W-1:0] alloc_id_i = '0;
  logic fill_valid_i = 1'b0, fill_wb_i = 1'b0, chain_pop_i = 1'b0;
  logic merge_o, full_o, fill_ready_o, chain_valid_o, chain_write_o;
  logic [ID_W-1:0] chain_id_o;
  logic [ADDR_W-1:0] chain_tag_o;
  logic [USED_W-1:0] used_o, peak_o;
  logic [CNT_W-1:0] miss_cnt_o, merge_cnt_o, fill_cnt_o;

  int n_checks = 0, n_fail = 0;
  int e_used = 0, e_peak = 0, e_miss = 0, e_merge = 0, e_fill = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  merge_mshr uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_addr_i(alloc_addr_i), .alloc_id_i(alloc_id_i),
    .alloc_write_i(alloc_write_i), .merge_o(merge_o), .full_o(full_o),
    .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i), .fill_wb_i(fill_wb_i),
    .fill_ready_o(fill_ready_o), .chain_valid_o(chain_valid_o), .chain_id_o(chain_id_o),
    .chain_write_o(chain_write_o), .chain_tag_o(chain_tag_o), .chain_pop_i(chain_pop_i),
    .used_o(used_o), .peak_o(peak_o), .miss_cnt_o(miss_cnt_o),
    .merge_cnt_o(merge_cnt_o), .fill_cnt_o(fill_cnt_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_push(input logic merged);
    e_miss++;
    if (merged) e_merge++;
    e_used++;
    if (e_used > e_peak) e_peak = e_used;
  endtask

  task automatic do_alloc(input logic [31:0] addr, input int id, input logic wr,
                          input logic exp_merge, input logic exp_full);
    @(negedge clk);
    alloc_valid_i = 1'b1; alloc_addr_i = addr; alloc_id_i = ID_W'(id); alloc_write_i = wr;
    #1;
    check("R2 merge", 32'(merge_o), 32'(exp_merge));
    check("R7 full", 32'(full_o), 32'(exp_full));
    @(posedge clk); #1;
    alloc_valid_i = 1'b0;
    if (!exp_full) model_push(exp_merge);
  endtask

  task automatic do_fill(input logic [31:0] addr, input logic wb,
                         input logic exp_ready, input logic exp_start);
    @(negedge clk);
    fill_valid_i = 1'b1; fill_addr_i = addr; fill_wb_i = wb;
    #1;
    check("R4 fill ready", 32'(fill_ready_o), 32'(exp_ready));
    @(posedge clk); #1;
    fill_valid_i = 1'b0; fill_wb_i = 1'b0;
    if (exp_start) e_fill++;
    check("R5 chain start", 32'(chain_valid_o), 32'(exp_start || !exp_ready));
  endtask

  task automatic do_pop(input int exp_id, input logic exp_wr, input logic exp_after);
    @(negedge clk);
    #1;
    check("R3 chain valid", 32'(chain_valid_o), 32'd1);
    check("R3 chain id", 32'(chain_id_o), 32'(exp_id));
    check("R3 chain write", 32'(chain_write_o), 32'(exp_wr));
    chain_pop_i = 1'b1;
    @(posedge clk); #1;
    chain_pop_i = 1'b0;
    e_used--;
    check("R6 valid after pop", 32'(chain_valid_o), 32'(exp_after));
  endtask

  task automatic check_stats(input string tag);
    check({"R8 used ", tag}, 32'(used_o), 32'(e_used));
    check({"R8 peak ", tag}, 32'(peak_o), 32'(e_peak));
    check({"R9 miss ", tag}, 32'(miss_cnt_o), 32'(e_miss));
    check({"R9 merge ", tag}, 32'(merge_cnt_o), 32'(e_merge));
    check({"R9 fill ", tag}, 32'(fill_cnt_o), 32'(e_fill));
  endtask

  task automatic t_reset();
    #1;
    check("R10 chain idle", 32'(chain_valid_o), 32'd0);
    check("R10 fill ready", 32'(fill_ready_o), 32'd1);
    check("R10 not full", 32'(full_o), 32'd0);
    check_stats("R10 reset");
  endtask

  task automatic t_merge_order();
    do_alloc(32'h1000, 1, 1'b0, 1'b0, 1'b0);
    do_alloc(32'h103C, 2, 1'b1, 1'b1, 1'b0);     // R1 same line
    do_alloc(32'h1040, 3, 1'b0, 1'b0, 1'b0);     // R1 next line
    do_fill(32'h1000, 1'b1, 1'b1, 1'b0);         // R5 writeback
    do_fill(32'h9000, 1'b0, 1'b1, 1'b0);         // R5 no group
    do_fill(32'h1010, 1'b0, 1'b1, 1'b1);
    check("R1 chain tag", chain_tag_o, 32'h1000);
    do_fill(32'h1040, 1'b0, 1'b0, 1'b0);         // R4 ignored while active
    check("R4 tag kept", chain_tag_o, 32'h1000);
    do_pop(1, 1'b0, 1'b1);
    do_pop(2, 1'b1, 1'b0);
    do_alloc(32'h1000, 4, 1'b0, 1'b0, 1'b0);     // R6 group released
    check_stats("merge");
    do_fill(32'h1000, 1'b0, 1'b1, 1'b1);
    do_pop(4, 1'b0, 1'b0);
    do_fill(32'h1040, 1'b0, 1'b1, 1'b1);         // R4 group survived
    do_pop(3, 1'b0, 1'b0);
    check_stats("drain1");
  endtask

  task automatic t_full();
    for (int i = 0; i < 4; i++) do_alloc(32'h2000 + 32'(i * 4), 10 + i, i[0], i != 0, 1'b0);
    do_alloc(32'h2008, 99, 1'b0, 1'b1, 1'b1);    // R7 group slots full
    do_alloc(32'h3000, 20, 1'b0, 1'b0, 1'b0);
    do_alloc(32'h4000, 21, 1'b0, 1'b0, 1'b0);
    do_alloc(32'h5000, 22, 1'b0, 1'b0, 1'b0);
    do_alloc(32'h6000, 98, 1'b0, 1'b0, 1'b1);    // R7 no free group
    do_alloc(32'h3004, 23, 1'b1, 1'b1, 1'b0);
    check_stats("full");
    do_fill(32'h2000, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) do_pop(10 + i, i[0], i != 3);  // R7 dropped id absent
    do_fill(32'h3000, 1'b0, 1'b1, 1'b1);
    do_pop(20, 1'b0, 1'b1);
    do_pop(23, 1'b1, 1'b0);
    do_fill(32'h4000, 1'b0, 1'b1, 1'b1);
    do_pop(21, 1'b0, 1'b0);
    do_fill(32'h5000, 1'b0, 1'b1, 1'b1);
    do_pop(22, 1'b0, 1'b0);
    check_stats("drain2");
  endtask

  task automatic t_append();
    do_alloc(32'h7000, 30, 1'b0, 1'b0, 1'b0);
    do_fill(32'h7000, 1'b0, 1'b1, 1'b1);
    do_alloc(32'h7020, 31, 1'b1, 1'b1, 1'b0);    // R11 append while active
    do_pop(30, 1'b0, 1'b1);
    // R11 append in the same cycle as the last pop
    @(negedge clk);
    alloc_valid_i = 1'b1; alloc_addr_i = 32'h7008; alloc_id_i = ID_W'(32); alloc_write_i = 1'b0;
    chain_pop_i = 1'b1;
    #1;
    check("R11 top before", 32'(chain_id_o), 32'd31);
    check("R11 merge", 32'(merge_o), 32'd1);
    @(posedge clk); #1;
    alloc_valid_i = 1'b0; chain_pop_i = 1'b0;
    model_push(1'b1);
    e_used--;
    check("R11 chain kept", 32'(chain_valid_o), 32'd1);
    do_pop(32, 1'b0, 1'b0);
    check_stats("append");
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_merge_order();
    t_full();
    t_append();
    repeat (2) @(negedge clk);
    report();
  end
endmodule